// File: doc/BRIEF.md
# Synchronous Burst Static RAM Model

This block is a synthesizable behavioural model of a synchronous static RAM that runs short bursts. Each word is made of byte lanes, and each lane carries a parity bit next to its eight data bits. An access begins when an address strobe is asserted. There are two strobes: one for the processor and one for the controller. The strobe captures the word address, and its two low bits seed a two-bit burst counter. While no strobe is asserted, the access continues from the stored address. A low burst-advance input moves the access to the next beat. A static order input selects linear or interleaved beat order.

Reads are registered. Data appears in the cycle after the edge at which its address was taken. Instead of a true bidirectional bus, the model has a separate data output and an output-drive flag. The drive flag follows the output-enable input, but three conditions force it off whatever output enable says: a write being presented, the deselected state, and doze. Doze is an active-high input that freezes every register, so the memory contents and the burst position both survive it.

Top module: `sync_burst_ram`

## Requirements
- R1: After reset, `q_drive` is low until the first read access.
- R2: A word is split into lanes. Lane b occupies bits [9b+8:9b] of `d` and `q`, and bit 9b+8 is that lane's parity bit. A controller strobe alone (`strb_ctl_n` low, `strb_cpu_n` high) with the chip selected and any `lane_wr_n` bit low writes `d` to `addr`. Only the lanes whose `lane_wr_n` bit is low are written.
- R3: A processor strobe with the chip selected starts a read at `addr`. The word is on `q`, with `q_drive` high, from the clock edge that sampled the strobe until the next edge.
- R4: If both strobes are low in the same cycle, the access is handled as a processor strobe. It is a read, `lane_wr_n` is ignored, and the memory is not changed.
- R5: A strobe loads `addr[1:0]` into the burst counter. In a following cycle with no strobe, `adv_n` low steps the counter by one beat. `adv_n` high repeats the current beat.
- R6: When `interleave` is 0, beat k of a burst started at low bits L goes to low bits (L+k) mod 4. The upper address bits stay fixed, and after four beats the burst wraps back to beat 0.
- R7: When `interleave` is 1, beat k goes to low bits L XOR k, with the same upper bits and the same wrap as in R6.
- R8: A cycle with no strobe, while a burst is active and some `lane_wr_n` bit is low, writes the enabled lanes of `d` at the current burst address.
- R9: `q_drive` is never high while `oe_n` is high.
- R10: While a write is being presented, `q_drive` is low, whatever `oe_n` says.
- R11: A strobe with the chip not selected performs no access and makes the device inactive. The chip is selected only when `sel_a_n` is low, `sel_b` is high and `sel_c_n` is low. While inactive, cycles with no strobe neither write nor drive. The cycle in which a new strobe leaves the inactive state is not driven.
- R12: While `doze` is high, no register changes, the memory is preserved, and `q_drive` is low. A burst resumes at the beat it had reached before doze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| doze | input | 1 | Freeze all state, outputs off |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low, wins ties |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| lane_wr_n | input | NLANE | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address |
| d | input | NLANE*LANE_W | Write data |
| q | output | NLANE*LANE_W | Read data register |
| q_drive | output | 1 | High when `q` would drive the bus |

## Verification
Two cases can fall in the same cycle: a processor strobe and a controller strobe, and a controller strobe that carries an active lane write. The bench provokes the collision by asserting both strobes together, with every lane enabled and data that is the inverse of the stored word. The following cycle must show the old word on `q` with the drive flag high. A later plain read at the same address must still return that old word, which proves that no lane was written.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_DESEL = 2'd3
  } sbr_op_e;

  // low address bits of one burst beat
  function automatic logic [1:0] beat_low(input logic [1:0] base,
                                          input logic [1:0] step,
                                          input logic       ilv);
    logic [1:0] r;
    if (ilv) r = base ^ step;
    else     r = 2'(base + step);
    return r;
  endfunction

endpackage

// File: rtl/sbr_burst_ctr.sv
module sbr_burst_ctr
  import sbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       load,
  input  logic       step,
  input  logic       ilv,
  input  logic [1:0] low_in,
  output logic [1:0] acc_low
);

  logic [1:0] base_q, base_d;
  logic [1:0] cnt_q,  cnt_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      base_d = low_in;
      cnt_d  = 2'd0;
    end else if (step) begin
      cnt_d  = 2'(cnt_q + 2'd1);
    end
    acc_low = beat_low(base_d, cnt_d, ilv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= 2'd0;
      cnt_q  <= 2'd0;
    end else if (en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/sbr_ctl.sv
module sbr_ctl
  import sbr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sel,
  input  logic strb_cpu_n,
  input  logic strb_ctl_n,
  input  logic adv_n,
  input  logic wr_any,
  output logic load,
  output logic step,
  output logic do_wr,
  output logic do_rd,
  output logic wr_now,
  output logic rd_q
);

  logic    active_q, active_d;
  logic    rd_d;
  logic    strobe, ctl_only;
  sbr_op_e op;

  always_comb begin
    strobe   = !strb_cpu_n || !strb_ctl_n;
    ctl_only = !strb_ctl_n && strb_cpu_n;
    op       = OP_IDLE;
    load     = 1'b0;
    step     = 1'b0;
    active_d = active_q;
    if (strobe) begin
      if (!sel) begin
        op       = OP_DESEL;
        active_d = 1'b0;
      end else begin
        load     = 1'b1;
        active_d = 1'b1;
        op       = (ctl_only && wr_any) ? OP_WRITE : OP_READ;
      end
    end else if (active_q) begin
      step = !adv_n;
      op   = wr_any ? OP_WRITE : OP_READ;
    end
    rd_d   = (op == OP_READ);
    wr_now = (op == OP_WRITE);
    do_wr  = en && wr_now;
    do_rd  = en && rd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
    end else if (en) begin
      active_q <= active_d;
      rd_q     <= rd_d;
    end
  end

endmodule

// File: rtl/sbr_array.sv
module sbr_array #(
  parameter int NLANE  = 2,
  parameter int LANE_W = 9,
  parameter int AW     = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [AW-1:0]           addr,
  input  logic [NLANE-1:0]        lane_we,
  input  logic [NLANE*LANE_W-1:0] wdata,
  output logic [NLANE*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_en && lane_we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/sync_burst_ram.sv
module sync_burst_ram
  import sbr_pkg::*;
#(
  parameter int NLANE  = 2,
  parameter int LANE_W = 9,
  parameter int AW     = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    doze,
  input  logic                    interleave,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    strb_cpu_n,
  input  logic                    strb_ctl_n,
  input  logic                    adv_n,
  input  logic [NLANE-1:0]        lane_wr_n,
  input  logic                    oe_n,
  input  logic [AW-1:0]           addr,
  input  logic [NLANE*LANE_W-1:0] d,
  output logic [NLANE*LANE_W-1:0] q,
  output logic                    q_drive
);

  localparam int UW = AW - 2;

  // reset: asserted at once, released on a clock edge
  logic rs_meta_q, rs_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_n_q    <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_n_q    <= rs_meta_q;
    end
  end

  logic          en, sel, wr_any;
  logic          load, step, do_wr, do_rd, wr_now, rd_q;
  logic [1:0]    acc_low;
  logic [UW-1:0] up_q, up_d;
  logic [AW-1:0] acc_addr;

  always_comb begin
    en     = !doze;
    sel    = !sel_a_n && sel_b && !sel_c_n;
    wr_any = |(~lane_wr_n);
  end

  sbr_ctl i_ctl (
    .clk        (clk),
    .rst_n      (rs_n_q),
    .en         (en),
    .sel        (sel),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .adv_n      (adv_n),
    .wr_any     (wr_any),
    .load       (load),
    .step       (step),
    .do_wr      (do_wr),
    .do_rd      (do_rd),
    .wr_now     (wr_now),
    .rd_q       (rd_q)
  );

  sbr_burst_ctr i_ctr (
    .clk     (clk),
    .rst_n   (rs_n_q),
    .en      (en),
    .load    (load),
    .step    (step),
    .ilv     (interleave),
    .low_in  (addr[1:0]),
    .acc_low (acc_low)
  );

  always_comb begin
    up_d     = load ? addr[AW-1:2] : up_q;
    acc_addr = {up_d, acc_low};
  end

  always_ff @(posedge clk or negedge rs_n_q) begin
    if (!rs_n_q)  up_q <= '0;
    else if (en)  up_q <= up_d;
  end

  sbr_array #(.NLANE(NLANE), .LANE_W(LANE_W), .AW(AW)) i_arr (
    .clk     (clk),
    .rst_n   (rs_n_q),
    .wr_en   (do_wr),
    .rd_en   (do_rd),
    .addr    (acc_addr),
    .lane_we (~lane_wr_n),
    .wdata   (d),
    .rdata   (q)
  );

  assign q_drive = rd_q && !oe_n && !doze && !wr_now;

endmodule

// File: rtl/sbr_chk.sv
module sbr_chk #(
  parameter int NLANE  = 2,
  parameter int LANE_W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    doze,
  input logic                    oe_n,
  input logic                    sel_a_n,
  input logic                    sel_b,
  input logic                    sel_c_n,
  input logic                    strb_cpu_n,
  input logic                    strb_ctl_n,
  input logic [NLANE-1:0]        lane_wr_n,
  input logic [NLANE*LANE_W-1:0] q,
  input logic                    q_drive
);

  logic chip_on;
  assign chip_on = !sel_a_n && sel_b && !sel_c_n;

  p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    q_drive |-> !oe_n);

  p_write_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_ctl_n && strb_cpu_n && chip_on && !(&lane_wr_n)) |-> !q_drive);

  p_desel_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && !chip_on && (!strb_cpu_n || !strb_ctl_n)) |=> !q_drive);

  p_doze_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    doze |=> $stable(q));

  p_doze_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    doze |-> !q_drive);

endmodule

bind sync_burst_ram sbr_chk #(.NLANE(NLANE), .LANE_W(LANE_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .doze       (doze),
  .oe_n       (oe_n),
  .sel_a_n    (sel_a_n),
  .sel_b      (sel_b),
  .sel_c_n    (sel_c_n),
  .strb_cpu_n (strb_cpu_n),
  .strb_ctl_n (strb_ctl_n),
  .lane_wr_n  (lane_wr_n),
  .q          (q),
  .q_drive    (q_drive)
);

// File: tb/test_sync_burst_ram.sv
`timescale 1ns/1ps
module test_sync_burst_ram;

  localparam int NLANE  = 2;
  localparam int LANE_W = 9;
  localparam int AW     = 6;
  localparam int W      = NLANE * LANE_W;
  localparam int DEPTH  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, doze, interleave, sel_a_n, sel_b, sel_c_n;
  logic strb_cpu_n, strb_ctl_n, adv_n, oe_n;
  logic [NLANE-1:0] lane_wr_n;
  logic [AW-1:0]    addr;
  logic [W-1:0]     d, q;
  logic             q_drive;

  logic [W-1:0] ref_mem [DEPTH];
  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  sync_burst_ram #(.NLANE(NLANE), .LANE_W(LANE_W), .AW(AW)) i_sync_burst_ram (
    .clk(clk), .rst_n(rst_n), .doze(doze), .interleave(interleave),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .lane_wr_n(lane_wr_n), .oe_n(oe_n), .addr(addr), .d(d),
    .q(q), .q_drive(q_drive)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] a, input int k, input logic ilv);
    logic [1:0] kk = 2'(k);
    logic [1:0] lo = ilv ? (a[1:0] ^ kk) : 2'(a[1:0] + kk);
    return {a[AW-1:2], lo};
  endfunction

  task automatic quiet();
    strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; adv_n = 1'b1;
    lane_wr_n = '1; sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    oe_n = 1'b0; doze = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ref_write(input logic [AW-1:0] a, input logic [W-1:0] v, input logic [NLANE-1:0] wn);
    for (int l = 0; l < NLANE; l++)
      if (!wn[l]) ref_mem[a][l*LANE_W +: LANE_W] = v[l*LANE_W +: LANE_W];
  endtask

  task automatic wr_single(input logic [AW-1:0] a, input logic [W-1:0] v, input logic [NLANE-1:0] wn);
    quiet();
    strb_ctl_n = 1'b0; addr = a; d = v; lane_wr_n = wn;
    #1 check("R10 drive off during write", W'(q_drive), W'(0));
    tick();
    ref_write(a, v, wn);
    quiet();
  endtask

  task automatic rd_single(input logic [AW-1:0] a, input string tag);
    quiet();
    strb_cpu_n = 1'b0; addr = a;
    tick();
    quiet();
    #1;
    check({tag, " R3 read data"}, q, ref_mem[a]);
    check({tag, " R3 drive on"}, W'(q_drive), W'(1));
  endtask

  task automatic burst_read(input logic [AW-1:0] a, input logic ilv);
    string ot = ilv ? "R7" : "R6";
    interleave = ilv;
    quiet();
    strb_cpu_n = 1'b0; addr = a;
    tick();
    quiet(); adv_n = 1'b0;
    #1 check({ot, " beat 0"}, q, ref_mem[beat_addr(a, 0, ilv)]);
    for (int k = 1; k <= 4; k++) begin
      tick();
      check({ot, " R5 beat step"}, q, ref_mem[beat_addr(a, k, ilv)]);
    end
    adv_n = 1'b1;
    tick();
    check("R5 hold beat", q, ref_mem[beat_addr(a, 4, ilv)]);
  endtask

  task automatic burst_write(input logic [AW-1:0] a, input logic ilv);
    logic [W-1:0] v;
    logic [NLANE-1:0] wn;
    interleave = ilv;
    quiet();
    v = W'($urandom);
    strb_ctl_n = 1'b0; addr = a; d = v; lane_wr_n = '0;
    tick();
    ref_write(a, v, '0);
    for (int k = 1; k < 4; k++) begin
      quiet();
      v = W'($urandom);
      wn = NLANE'($urandom_range(0, (1 << NLANE) - 2));
      adv_n = 1'b0; d = v; lane_wr_n = wn;
      #1 check("R10 drive off in burst write", W'(q_drive), W'(0));
      tick();
      ref_write(beat_addr(a, k, ilv), v, wn);
    end
    quiet();
    for (int k = 0; k < 4; k++) rd_single(beat_addr(a, k, ilv), "R8");
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a, b;
    logic [W-1:0]  v;
    void'($urandom(32'h5EED1234));
    quiet();
    interleave = 1'b1; addr = '0; d = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();
    check("R1 no drive after reset", W'(q_drive), W'(0));

    // fill memory (R2)
    for (int i = 0; i < DEPTH; i++) wr_single(AW'(i), W'($urandom), '0);
    rd_single(6'd5, "R2 full word");

    // lane masking (R2): write only lane 1, then only lane 0
    wr_single(6'd9, 18'h3FFFF, 2'b10);
    rd_single(6'd9, "R2 lane0 only");
    wr_single(6'd9, 18'h00000, 2'b01);
    rd_single(6'd9, "R2 lane1 only");

    // bursts in both orders, including wrap
    burst_read(6'd6, 1'b0);
    burst_read(6'd6, 1'b1);
    burst_read(6'd17, 1'b0);
    burst_read(6'd19, 1'b1);
    burst_write(6'd22, 1'b0);
    burst_write(6'd41, 1'b1);

    // strobe priority (R4)
    a = 6'd30;
    quiet();
    strb_cpu_n = 1'b0; strb_ctl_n = 1'b0; addr = a; d = ~ref_mem[a]; lane_wr_n = '0;
    tick();
    quiet();
    #1 check("R4 collision reads old word", q, ref_mem[a]);
    check("R4 collision drives", W'(q_drive), W'(1));
    rd_single(a, "R4 memory untouched");

    // output enable (R9)
    rd_single(6'd12, "R9 setup");
    oe_n = 1'b1;
    #1 check("R9 oe high no drive", W'(q_drive), W'(0));
    oe_n = 1'b0;
    #1 check("R9 oe low drives", W'(q_drive), W'(1));

    // deselect by each select input (R11)
    for (int s = 0; s < 3; s++) begin
      a = AW'(40 + s);
      b = AW'(50 + s);
      rd_single(a, "R11 setup");
      quiet();
      strb_cpu_n = 1'b0; addr = b;
      if (s == 0) sel_a_n = 1'b1;
      if (s == 1) sel_b   = 1'b0;
      if (s == 2) sel_c_n = 1'b1;
      tick();
      quiet();
      adv_n = 1'b0; lane_wr_n = '0; d = ~ref_mem[a];
      #1 check("R11 no drive after deselect", W'(q_drive), W'(0));
      tick();
      check("R11 inactive cycle no drive", W'(q_drive), W'(0));
      quiet();
      strb_cpu_n = 1'b0; addr = b;
      #1 check("R11 leaving cycle undriven", W'(q_drive), W'(0));
      tick();
      quiet();
      #1 check("R11 read after reselect", q, ref_mem[b]);
      rd_single(a, "R11 no stray write");
    end

    // doze (R12)
    a = 6'd3; b = 6'd60;
    rd_single(a, "R12 setup");
    quiet();
    doze = 1'b1; strb_ctl_n = 1'b0; addr = b; d = ~ref_mem[b]; lane_wr_n = '0;
    #1 check("R12 no drive in doze", W'(q_drive), W'(0));
    tick();
    check("R12 output held", q, ref_mem[a]);
    quiet();
    rd_single(b, "R12 memory preserved");
    interleave = 1'b1;
    quiet();
    strb_cpu_n = 1'b0; addr = 6'd33;
    tick();
    quiet(); adv_n = 1'b0; doze = 1'b1;
    tick();
    doze = 1'b0;
    tick();
    check("R12 burst resumes at beat 1", q, ref_mem[beat_addr(6'd33, 1, 1'b1)]);

    // random mix
    for (int i = 0; i < 300; i++) begin
      a = AW'($urandom);
      case ($urandom_range(0, 3))
        0: wr_single(a, W'($urandom), NLANE'($urandom_range(0, (1 << NLANE) - 2)));
        1: rd_single(a, "R3 random");
        2: burst_read(a, 1'($urandom));
        default: begin
          v = W'($urandom);
          wr_single(a, v, '0);
          rd_single(a, "R2 random");
        end
      endcase
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule